// File: doc/BRIEF.md
# UART-Timed 1-Wire Bus Master

This block drives a 1-Wire bus without a dedicated slot timer. Every bus slot is produced as one ten-bit serial frame on an open-drain line: a low start bit, eight pattern bits sent least-significant first, and a high stop bit. The choice of bit period and pattern byte sets how long the line is held low. A slow bit period is used for reset and presence slots, and a fast one is used for read and write slots. The receive side samples the line in the middle of every bit while the frame is being sent. A device on the bus that pulls the line low changes the echoed byte, and each result comes from comparing that echo with the byte that was sent.

Commands enter through a valid/ready port. `cmd_ready` is high only while no slot is in progress. A command is taken in any cycle where both `cmd_valid` and `cmd_ready` are high. While a slot runs, the upstream side holds its command and waits. Results have no back-pressure: they appear on a one-cycle `done` pulse, and the consumer must capture them in that cycle. The two bit periods are parameters given in system clock cycles. The pattern bytes are also parameters, so the low times can be corrected when the achievable period differs from the nominal one.

Top module: `owm_uart_master`

## Requirements
- R1: After reset, and whenever no slot is running, `cmd_ready` is 1, `bus_drive_low` is 0 and `done` is 0. A command is accepted in a cycle where both `cmd_valid` and `cmd_ready` are 1. The `cmd_op` encoding is: 0 = reset/presence, 1 = write bit, 2 = read bit, 3 = no operation.
- R2: A reset slot uses `DIV_RST` clock cycles per bit and sends `PAT_RESET` (default 0xF0). From the cycle after acceptance, bit k of the frame (k = 0 start, k = 1..8 pattern bit k-1, k = 9 stop) occupies cycles k*D to k*D+D-1. `bus_drive_low` is 1 exactly when the bit is the start bit or a pattern bit that is 0.
- R3: A write slot uses `DIV_BIT` cycles per bit. It sends `PAT_ZERO` (default 0x80) when `cmd_bit` is 0 and `PAT_ONE` (default 0xFF) when `cmd_bit` is 1, with the same frame layout as R2.
- R4: A read slot uses `DIV_BIT` cycles per bit and sends `PAT_ONE`. `done_bit` is 1 when the echoed pattern byte equals `PAT_ONE`, and 0 otherwise.
- R5: For a reset slot, `done_presence` is 1 when the echoed pattern byte differs from `PAT_RESET`.
- R6: Each frame bit is sampled near the middle of its period. `done_short` is 1 when the stop bit was sampled low.
- R7: `cmd_ready` stays 0 for the whole frame. `done` is a one-cycle pulse in the cycle right after the stop bit ends, which is 10*D cycles after the first slot cycle. `cmd_ready` returns to 1 in that same cycle.
- R8: A command with `cmd_op` = 3 is accepted but starts no slot. It produces no `done` pulse and no low drive.
- R9: `done_presence`, `done_bit` and `done_short` are 0 whenever `done` is 0. `done_presence` is also 0 for slots that are not reset slots, and `done_bit` is 0 for slots that are not read slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Master idle, command can be taken |
| cmd_op | input | 2 | Slot type: 0 reset, 1 write, 2 read, 3 none |
| cmd_bit | input | 1 | Bit value for a write slot |
| bus_drive_low | output | 1 | 1 pulls the open-drain line low |
| bus_in | input | 1 | Sensed line level (asynchronous) |
| done | output | 1 | One-cycle slot completion pulse |
| done_presence | output | 1 | Device answered the reset slot |
| done_bit | output | 1 | Bit value returned by a read slot |
| done_short | output | 1 | Stop bit was sampled low (bus held low) |

## Verification
A wrong bit counter or a wrong divisor shows up at once in `bus_drive_low`: the start bit or a pattern bit ends in the wrong cycle, or the `done` pulse moves off cycle 10*D. Both are seen within a single bit period of the fault. A sampler that is misaligned or loses a bit is only visible when `done` fires. It then shows as a wrong presence flag, read bit or short flag, so the device model pulls the line across whole bits in several placements: inside the high half of a reset frame, over bits that are already low, and over the stop bit. A stuck busy state shows as `cmd_ready` failing to return in the completion cycle.

// File: rtl/owm_pkg.sv
`timescale 1ns/1ps
package owm_pkg;
  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_NONE  = 2'd3
  } owm_op_e;

  // start + 8 pattern bits + stop
  localparam int FRAME_BITS = 10;
  localparam int PAT_W      = 8;
endpackage

// File: rtl/owm_baud_div.sv
`timescale 1ns/1ps
// Bit-period counter; the divisor is latched when a frame is loaded.
module owm_baud_div #(
  parameter int DIV_SLOW = 20833,
  parameter int DIV_FAST = 1736,
  localparam int CW = $clog2(DIV_SLOW + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic sel_slow,
  input  logic run,
  output logic bit_end,
  output logic mid_tick
);
  logic [CW-1:0] div_q;
  logic [CW-1:0] cnt;

  assign bit_end  = run && (cnt == div_q - 1'b1);
  assign mid_tick = run && (cnt == (div_q >> 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= CW'(DIV_FAST);
      cnt   <= '0;
    end else if (load) begin
      div_q <= sel_slow ? CW'(DIV_SLOW) : CW'(DIV_FAST);
      cnt   <= '0;
    end else if (run) begin
      cnt <= bit_end ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/owm_tx_shift.sv
`timescale 1ns/1ps
// Frame shifter: bit 0 of the register is the bit currently on the line.
module owm_tx_shift
  import owm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PAT_W-1:0] pattern,
  input  logic             shift,
  input  logic             run,
  output logic             drive_low
);
  logic [FRAME_BITS-1:0] sh;

  assign drive_low = run && !sh[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh <= '1;
    end else if (load) begin
      sh <= {1'b1, pattern, 1'b0};
    end else if (shift) begin
      sh <= {1'b1, sh[FRAME_BITS-1:1]};
    end
  end
endmodule

// File: rtl/owm_rx_sample.sv
`timescale 1ns/1ps
// Synchronises the line and collects one sample per frame bit.
// The start-bit sample drops out of the register, so after ten samples
// the register holds {stop, pattern[7:0]}.
module owm_rx_sample
  import owm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line,
  input  logic             clear,
  input  logic             sample,
  output logic [PAT_W-1:0] echo,
  output logic             stop_high
);
  logic          line_s;
  logic [PAT_W:0] rx_sh;

  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rst_n) line_s <= 1'b1;
        else        line_s <= line;
      end
    end else begin : g_syncn
      logic [SYNC_STAGES-1:0] sy;
      always_ff @(posedge clk) begin
        if (!rst_n) sy <= '1;
        else        sy <= {sy[SYNC_STAGES-2:0], line};
      end
      assign line_s = sy[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_sh <= '1;
    end else if (clear) begin
      rx_sh <= '1;
    end else if (sample) begin
      rx_sh <= {line_s, rx_sh[PAT_W:1]};
    end
  end

  assign echo      = rx_sh[PAT_W-1:0];
  assign stop_high = rx_sh[PAT_W];
endmodule

// File: rtl/owm_uart_master.sv
`timescale 1ns/1ps
module owm_uart_master
  import owm_pkg::*;
#(
  parameter int          DIV_RST     = 20833,
  parameter int          DIV_BIT     = 1736,
  parameter logic [7:0]  PAT_RESET   = 8'hF0,
  parameter logic [7:0]  PAT_ZERO    = 8'h80,
  parameter logic [7:0]  PAT_ONE     = 8'hFF,
  parameter int          SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [1:0] cmd_op,
  input  logic       cmd_bit,
  output logic       bus_drive_low,
  input  logic       bus_in,
  output logic       done,
  output logic       done_presence,
  output logic       done_bit,
  output logic       done_short
);
  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);

  logic             busy;
  logic [BW-1:0]    bit_idx;
  owm_op_e          op_q;
  logic             accept;
  logic             start;
  logic [PAT_W-1:0] pattern;
  logic             bit_end;
  logic             mid_tick;
  logic [PAT_W-1:0] echo;
  logic             stop_high;

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;
  assign start     = accept && (owm_op_e'(cmd_op) != OP_NONE);

  always_comb begin
    case (owm_op_e'(cmd_op))
      OP_RESET: pattern = PAT_RESET;
      OP_WRITE: pattern = cmd_bit ? PAT_ONE : PAT_ZERO;
      default:  pattern = PAT_ONE;
    endcase
  end

  owm_baud_div #(
    .DIV_SLOW (DIV_RST),
    .DIV_FAST (DIV_BIT)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .sel_slow (owm_op_e'(cmd_op) == OP_RESET),
    .run      (busy),
    .bit_end  (bit_end),
    .mid_tick (mid_tick)
  );

  owm_tx_shift u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .pattern   (pattern),
    .shift     (bit_end),
    .run       (busy),
    .drive_low (bus_drive_low)
  );

  owm_rx_sample #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .line      (bus_in),
    .clear     (start),
    .sample    (mid_tick),
    .echo      (echo),
    .stop_high (stop_high)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy          <= 1'b0;
      bit_idx       <= '0;
      op_q          <= OP_RESET;
      done          <= 1'b0;
      done_presence <= 1'b0;
      done_bit      <= 1'b0;
      done_short    <= 1'b0;
    end else begin
      done          <= 1'b0;
      done_presence <= 1'b0;
      done_bit      <= 1'b0;
      done_short    <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        bit_idx <= '0;
        op_q    <= owm_op_e'(cmd_op);
      end else if (busy && bit_end) begin
        if (bit_idx == LAST_BIT) begin
          busy          <= 1'b0;
          done          <= 1'b1;
          done_presence <= (op_q == OP_RESET) && (echo != PAT_RESET);
          done_bit      <= (op_q == OP_READ) && (echo == PAT_ONE);
          done_short    <= !stop_high;
        end else begin
          bit_idx <= bit_idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/owm_uart_master_chk.sv
`timescale 1ns/1ps
module owm_uart_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_op,
  input logic       bus_drive_low,
  input logic       done,
  input logic       done_presence,
  input logic       done_bit,
  input logic       done_short
);
  // R2 R3 R4: an accepted slot drives its start bit in the next cycle
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op != 2'd3) |=> (bus_drive_low && !cmd_ready));

  // R7: low drive only while busy
  p_drive_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive_low |-> !cmd_ready);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cmd_ready && !bus_drive_low));

  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(!cmd_ready));

  p_none_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 2'd3) |=> (cmd_ready && !bus_drive_low && !done));

  p_results_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_presence || done_bit || done_short) |-> done);
endmodule

bind owm_uart_master owm_uart_master_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_valid     (cmd_valid),
  .cmd_ready     (cmd_ready),
  .cmd_op        (cmd_op),
  .bus_drive_low (bus_drive_low),
  .done          (done),
  .done_presence (done_presence),
  .done_bit      (done_bit),
  .done_short    (done_short)
);

// File: tb/owm_uart_master_test.sv
`timescale 1ns/1ps
module owm_uart_master_test;
  localparam int DR = 40;
  localparam int DB = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic       cmd_bit = 1'b0;
  logic       bus_drive_low;
  logic       bus_in;
  logic       done, done_presence, done_bit, done_short;
  logic       dev_pull = 1'b0;

  assign bus_in = !(bus_drive_low || dev_pull);

  owm_uart_master #(.DIV_RST(DR), .DIV_BIT(DB)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_bit(cmd_bit), .bus_drive_low(bus_drive_low),
    .bus_in(bus_in), .done(done), .done_presence(done_presence),
    .done_bit(done_bit), .done_short(done_short));

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // reference model state
  bit         m_active = 1'b0;
  bit         m_start_next = 1'b0;
  int         m_t = 0;
  int         m_D = DB;
  logic [7:0] m_pat = 8'hFF;
  logic [1:0] m_op = 2'd0;
  logic [1:0] s_op = 2'd0;
  logic       s_bit = 1'b0;
  int         pa = 0;   // device pulls low over frame bits [pa, pb)
  int         pb = 0;

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic f_low(int t, int d, logic [7:0] pat);
    int b = t / d;
    if (b == 0) return 1'b1;
    if (b <= 8) return !pat[b-1];
    return 1'b0;
  endfunction

  function automatic logic pulled(int b);
    return (b >= pa) && (b < pb);
  endfunction

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic e_drive, e_ready, e_done;
      string tg;
      if (m_start_next) begin
        m_active = 1'b1;
        m_t      = 0;
        m_op     = s_op;
        m_D      = (s_op == 2'd0) ? DR : DB;
        m_pat    = (s_op == 2'd0) ? 8'hF0 : (s_op == 2'd1 && !s_bit) ? 8'h80 : 8'hFF;
        m_start_next = 1'b0;
      end
      if (m_active) begin
        e_drive = (m_t < 10*m_D) ? f_low(m_t, m_D, m_pat) : 1'b0;
        e_done  = (m_t == 10*m_D);
        e_ready = e_done;
        tg = (m_op == 2'd0) ? "R2" : (m_op == 2'd1) ? "R3" : "R4";
      end else begin
        e_drive = 1'b0; e_done = 1'b0; e_ready = 1'b1; tg = "R1";
      end
      chk(tg, "bus_drive_low", bus_drive_low, e_drive);
      chk(m_active ? "R7" : "R1", "cmd_ready", cmd_ready, e_ready);
      chk(m_active ? "R7" : "R8", "done", done, e_done);
      if (e_done) begin
        logic [7:0] echo;
        for (int k = 0; k < 8; k++) echo[k] = m_pat[k] && !pulled(k+1);
        chk(m_op == 2'd0 ? "R5" : "R9", "done_presence", done_presence,
            (m_op == 2'd0) && (echo != 8'hF0));
        chk(m_op == 2'd2 ? "R4" : "R9", "done_bit", done_bit,
            (m_op == 2'd2) && (echo == 8'hFF));
        chk("R6", "done_short", done_short, pulled(9));
      end else begin
        chk("R9", "result flags idle", done_presence || done_bit || done_short, 1'b0);
      end
      if (m_active) begin
        if (m_t == 10*m_D) m_active = 1'b0;
        else m_t++;
      end
      dev_pull = m_active && pulled(m_t / m_D);
      if (e_ready && cmd_valid && cmd_op != 2'd3) begin
        m_start_next = 1'b1;
        s_op = cmd_op;
        s_bit = cmd_bit;
      end
    end
  end

  task automatic issue(input logic [1:0] op, input logic b);
    @(posedge clk); #1;
    cmd_op = op; cmd_bit = b; cmd_valid = 1'b1;
    do @(negedge clk); while (!cmd_ready);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(posedge clk); while (m_active || m_start_next);
    repeat (3) @(posedge clk);
  endtask

  task automatic slot(input logic [1:0] op, input logic b, input int a, input int e);
    @(posedge clk); #1;
    pa = a; pb = e;
    issue(op, b);
    wait_idle();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset cmd_ready", cmd_ready, 1'b1);
    chk("R1", "reset bus_drive_low", bus_drive_low, 1'b0);
    chk("R1", "reset done", done, 1'b0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    // reset slots: no device, answering device, pull over low bits, short
    slot(2'd0, 1'b0, 0, 0);
    slot(2'd0, 1'b0, 6, 9);
    slot(2'd0, 1'b0, 0, 4);
    slot(2'd0, 1'b0, 0, 10);
    // write slots
    slot(2'd1, 1'b0, 0, 0);
    slot(2'd1, 1'b1, 0, 0);
    slot(2'd1, 1'b1, 0, 3);
    // read slots: 1, held low early, late pull, short
    slot(2'd2, 1'b0, 0, 0);
    slot(2'd2, 1'b0, 0, 4);
    slot(2'd2, 1'b0, 6, 9);
    slot(2'd2, 1'b0, 0, 10);
    // no-operation command (R8)
    slot(2'd3, 1'b0, 0, 0);
    // back-to-back commands offered while busy (R7)
    @(posedge clk); #1;
    pa = 0; pb = 0;
    issue(2'd2, 1'b0);
    issue(2'd1, 1'b0);
    issue(2'd0, 1'b0);
    wait_idle();
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule